// File: doc/BRIEF.md
# Latched Open-Drain Select Output Controller

This block drives the pull-down enable of an active-low open-drain select pin. Each command on the two-wire bus carries a one-bit select request in its control byte. The block captures that bit while the control byte is being clocked in. It then applies the bit to the pin only at one fixed SCL rising edge, and which edge that is depends on the command type. Between updates the pin keeps its last value, so other circuitry can be enabled and left enabled across any number of later bus transactions.

A bus decoder sits upstream of the block. It supplies one-cycle strobes for SCL rising edges, START and STOP, along with the bit and byte position of each rising edge. It also supplies the command code, a control-code match flag, an ID match flag and the device's assigned or unassigned status. The open-drain pad sits outside the block and is driven by `pd_en_o`.

Top module: `ext_select_drv`

## Requirements
- R1: While reset is asserted, and after it is released, `pd_en_o` is 0 (pin released) until a valid update occurs.
- R2: The select bit is the sample taken at byte 0, bit position 4 (bit positions 0..7 go MSB first and position 8 is the acknowledge). A value of 1 sets `pd_en_o` and a value of 0 clears it.
- R3: For read (`cmd_i`=001), write (010) and set-protect (000) with `id_match_i`=1, the update takes effect at the rising edge at byte 2, bit 0. This is the first rising edge after the ID-byte acknowledge. `pd_en_o` shows the new value in the next clock cycle.
- R4: For assign (`cmd_i`=100), the update happens at the same edge as in R3, but only when `unassigned_i`=1. An already-assigned device ignores the select bit of an assign command.
- R5: For read, write or set-protect with `id_match_i`=0, `pd_en_o` does not change.
- R6: For clear (`cmd_i`=110), nothing changes at the byte 2, bit 0 edge. The update is applied when STOP is detected after that edge, and the ID match flag is not consulted.
- R7: A partial write consists of the control byte, the ID byte, one rising edge at byte 2, bit 0, and then STOP. It updates at that rising edge, and the value survives the STOP.
- R8: A START or STOP that arrives before a command's update point leaves `pd_en_o` unchanged. This applies to a clear that stops before the byte 2, bit 0 edge.
- R9: `pd_en_o` holds its value while idle and changes only in the cycle after an SCL-rise or STOP strobe.
- R10: A command whose control code does not match (`ctrl_ok_i`=0 at the select-bit sample) does not change `pd_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | START detected strobe |
| stop_i | input | 1 | STOP detected strobe |
| scl_rise_i | input | 1 | SCL rising-edge strobe |
| bit_idx_i | input | BIT_W | Bit position of this rising edge (0..7 data, 8 acknowledge) |
| byte_idx_i | input | BYTE_W | Byte position in the command (0 control, 1 ID) |
| sda_i | input | 1 | SDA level sampled at this rising edge |
| ctrl_ok_i | input | 1 | Control code matched |
| cmd_i | input | 3 | Command code from the control byte |
| id_match_i | input | 1 | ID byte matched this device |
| unassigned_i | input | 1 | Device has no assigned ID yet |
| pd_en_o | output | 1 | Pull-down enable for the open-drain select pin |

## Verification
The assertions check several rules on every cycle. The output may change only after an SCL-rise or STOP strobe. A change on a rising edge must fall on the byte 2, bit 0 position. A change at STOP must belong to a clear command. An assign command must never move the pin of an assigned device. Reset must hold the pin released. Only the bench scenarios can show the value side of the behaviour: that the captured select bit is the one applied, that a clear waits for STOP, that aborted and mismatched commands leave a previously set pin alone, and that the state survives idle time.

// File: rtl/ext_sel_pkg.sv
package ext_sel_pkg;
  localparam int CMD_W = 3;

  localparam logic [CMD_W-1:0] CMD_PROTECT = 3'b000;
  localparam logic [CMD_W-1:0] CMD_READ    = 3'b001;
  localparam logic [CMD_W-1:0] CMD_WRITE   = 3'b010;
  localparam logic [CMD_W-1:0] CMD_ASSIGN  = 3'b100;
  localparam logic [CMD_W-1:0] CMD_CLEAR   = 3'b110;

  // commands applied at the first rising edge after the ID acknowledge
  function automatic logic is_edge_cmd(logic [CMD_W-1:0] c);
    return (c == CMD_PROTECT) || (c == CMD_READ) || (c == CMD_WRITE) || (c == CMD_ASSIGN);
  endfunction
endpackage

// File: rtl/ext_sel_capture.sv
module ext_sel_capture #(
  parameter int BIT_W  = 4,
  parameter int BYTE_W = 3,
  parameter int OE_POS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  input  logic [BYTE_W-1:0] byte_idx_i,
  input  logic              sda_i,
  input  logic              ctrl_ok_i,
  output logic              armed_o,
  output logic              oe_o
);
  logic at_oe;
  assign at_oe = scl_rise_i && (byte_idx_i == '0) && (bit_idx_i == BIT_W'(OE_POS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      oe_o    <= 1'b0;
    end else if (start_i || stop_i) begin
      armed_o <= 1'b0;
    end else if (at_oe) begin
      oe_o    <= sda_i;
      armed_o <= ctrl_ok_i;
    end
  end
endmodule

// File: rtl/ext_sel_sched.sv
module ext_sel_sched
  import ext_sel_pkg::*;
#(
  parameter int BIT_W    = 4,
  parameter int BYTE_W   = 3,
  parameter int UPD_BYTE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  input  logic [BYTE_W-1:0] byte_idx_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              id_match_i,
  input  logic              unassigned_i,
  input  logic              armed_i,
  output logic              apply_o
);
  logic at_upd, edge_ok, clr_pend_q;

  assign at_upd  = armed_i && scl_rise_i &&
                   (byte_idx_i == BYTE_W'(UPD_BYTE)) && (bit_idx_i == '0);
  assign edge_ok = is_edge_cmd(cmd_i) &&
                   ((cmd_i == CMD_ASSIGN) ? unassigned_i : id_match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          clr_pend_q <= 1'b0;
    else if (start_i || stop_i)           clr_pend_q <= 1'b0;
    else if (at_upd && cmd_i == CMD_CLEAR) clr_pend_q <= 1'b1;
  end

  assign apply_o = (at_upd && edge_ok) || (stop_i && clr_pend_q && armed_i);
endmodule

// File: rtl/ext_sel_latch.sv
module ext_sel_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic apply_i,
  input  logic val_i,
  output logic pd_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pd_en_o <= 1'b0;
    else if (apply_i) pd_en_o <= val_i;
  end
endmodule

// File: rtl/ext_select_drv.sv
module ext_select_drv
  import ext_sel_pkg::*;
#(
  parameter int BIT_W   = 4,
  parameter int BYTE_W  = 3,
  parameter int OE_POS  = 4,
  parameter int ID_BYTE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  input  logic [BYTE_W-1:0] byte_idx_i,
  input  logic              sda_i,
  input  logic              ctrl_ok_i,
  input  logic [2:0]        cmd_i,
  input  logic              id_match_i,
  input  logic              unassigned_i,
  output logic              pd_en_o
);
  localparam int UPD_BYTE = ID_BYTE + 1;

  logic armed, oe, apply;

  ext_sel_capture #(.BIT_W(BIT_W), .BYTE_W(BYTE_W), .OE_POS(OE_POS)) u_cap (
    .clk_i, .rst_ni, .start_i, .stop_i, .scl_rise_i, .bit_idx_i, .byte_idx_i,
    .sda_i, .ctrl_ok_i, .armed_o(armed), .oe_o(oe)
  );

  ext_sel_sched #(.BIT_W(BIT_W), .BYTE_W(BYTE_W), .UPD_BYTE(UPD_BYTE)) u_sched (
    .clk_i, .rst_ni, .start_i, .stop_i, .scl_rise_i, .bit_idx_i, .byte_idx_i,
    .cmd_i, .id_match_i, .unassigned_i, .armed_i(armed), .apply_o(apply)
  );

  ext_sel_latch u_latch (
    .clk_i, .rst_ni, .apply_i(apply), .val_i(oe), .pd_en_o
  );
endmodule

// File: rtl/ext_select_drv_chk.sv
module ext_select_drv_chk #(
  parameter int BIT_W   = 4,
  parameter int BYTE_W  = 3,
  parameter int ID_BYTE = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              scl_rise_i,
  input logic [BIT_W-1:0]  bit_idx_i,
  input logic [BYTE_W-1:0] byte_idx_i,
  input logic [2:0]        cmd_i,
  input logic              unassigned_i,
  input logic              pd_en_o
);
  localparam int UPD_BYTE = ID_BYTE + 1;

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_released_chk: assert (!pd_en_o);
  end

  // R9
  only_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pd_en_o) |-> $past(scl_rise_i || stop_i));

  // R3
  edge_position_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(pd_en_o) && !$past(stop_i)) |->
      $past(byte_idx_i == BYTE_W'(UPD_BYTE) && bit_idx_i == '0));

  // R6
  stop_only_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(pd_en_o) && $past(stop_i)) |-> $past(cmd_i == 3'b110));

  // R4
  assigned_ignores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pd_en_o) |-> !$past(cmd_i == 3'b100 && !unassigned_i));
endmodule

bind ext_select_drv ext_select_drv_chk #(.BIT_W(BIT_W), .BYTE_W(BYTE_W), .ID_BYTE(ID_BYTE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .scl_rise_i(scl_rise_i),
  .bit_idx_i(bit_idx_i), .byte_idx_i(byte_idx_i), .cmd_i(cmd_i),
  .unassigned_i(unassigned_i), .pd_en_o(pd_en_o)
);

// File: tb/ext_select_drv_bench.sv
`timescale 1ns/1ps
module ext_select_drv_bench;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, scl_rise_i = 0, sda_i = 0;
  logic [3:0] bit_idx_i = '0;
  logic [2:0] byte_idx_i = '0;
  logic ctrl_ok_i = 1, id_match_i = 1, unassigned_i = 1;
  logic [2:0] cmd_i = 3'b010;
  logic pd_en_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_select_drv u_ext_select_drv (
    .clk_i(clk), .rst_ni, .start_i, .stop_i, .scl_rise_i, .bit_idx_i, .byte_idx_i,
    .sda_i, .ctrl_ok_i, .cmd_i, .id_match_i, .unassigned_i, .pd_en_o
  );

  task automatic chk(string req, logic exp);
    n_run++;
    if (pd_en_o !== exp) begin
      n_fail++;
      $display("FAIL %s: pd_en_o=%b expected %b", req, pd_en_o, exp);
    end
  endtask

  task automatic rise(int by, int bi, logic d);
    @(negedge clk);
    byte_idx_i = 3'(by); bit_idx_i = 4'(bi); sda_i = d; scl_rise_i = 1;
    @(negedge clk);
    scl_rise_i = 0;
  endtask

  task automatic send_byte(int by, logic [7:0] v);
    for (int i = 0; i < 8; i++) rise(by, i, v[7-i]);
    rise(by, 8, 1'b0);
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
  endtask

  task automatic ctrl_id(logic oe, logic [2:0] cmd);
    do_start();
    cmd_i = cmd;
    send_byte(0, {4'b0110, oe, cmd});
    send_byte(1, 8'h5a);
  endtask

  // full read/write style command through byte 2 then STOP
  task automatic full_cmd(logic oe, logic [2:0] cmd);
    ctrl_id(oe, cmd);
    send_byte(2, 8'h33);
    do_stop();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 during reset", 1'b0);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    chk("R1 after reset", 1'b0);
  endtask

  task automatic t_partial_write();
    id_match_i = 1;
    ctrl_id(1'b1, 3'b010);
    chk("R3 not before update edge", 1'b0);
    rise(2, 0, 1'b0);
    chk("R2 R3 set at byte2 bit0", 1'b1);
    do_stop();
    chk("R7 partial write kept", 1'b1);
  endtask

  task automatic t_hold();
    repeat (25) @(negedge clk);
    chk("R9 held while idle", 1'b1);
  endtask

  task automatic t_read_release();
    ctrl_id(1'b0, 3'b001);
    rise(2, 0, 1'b1);
    chk("R2 read releases", 1'b0);
    do_stop();
    chk("R2 release kept", 1'b0);
    full_cmd(1'b1, 3'b000);
    chk("R3 protect sets", 1'b1);
  endtask

  task automatic t_mismatch();
    id_match_i = 0;
    full_cmd(1'b0, 3'b010);
    chk("R5 mismatch write ignored", 1'b1);
    full_cmd(1'b0, 3'b001);
    chk("R5 mismatch read ignored", 1'b1);
    id_match_i = 1;
  endtask

  task automatic t_assign();
    id_match_i = 0;
    unassigned_i = 0;
    full_cmd(1'b0, 3'b100);
    chk("R4 assigned ignores", 1'b1);
    unassigned_i = 1;
    full_cmd(1'b0, 3'b100);
    chk("R4 unassigned applies", 1'b0);
    id_match_i = 1;
  endtask

  task automatic t_clear();
    id_match_i = 0;
    ctrl_id(1'b1, 3'b110);
    rise(2, 0, 1'b0);
    chk("R6 no change at edge", 1'b0);
    for (int i = 1; i < 8; i++) rise(2, i, 1'b1);
    rise(2, 8, 1'b0);
    chk("R6 no change before stop", 1'b0);
    do_stop();
    chk("R6 applied at stop", 1'b1);
    id_match_i = 1;
  endtask

  task automatic t_abort();
    ctrl_id(1'b0, 3'b010);
    do_stop();
    chk("R8 write stopped after ID", 1'b1);
    do_start();
    cmd_i = 3'b010;
    send_byte(0, 8'b0110_0010);
    rise(1, 0, 1'b0);
    do_start();
    rise(2, 0, 1'b0);
    do_stop();
    chk("R8 repeated start aborts", 1'b1);
    ctrl_id(1'b0, 3'b110);
    do_stop();
    chk("R8 clear stopped early", 1'b1);
  endtask

  task automatic t_ctrl_code();
    ctrl_ok_i = 0;
    full_cmd(1'b0, 3'b010);
    chk("R10 bad control code", 1'b1);
    ctrl_ok_i = 1;
    full_cmd(1'b0, 3'b010);
    chk("R10 good code releases", 1'b0);
  endtask

  initial begin
    t_reset();
    t_partial_write();
    t_hold();
    t_read_release();
    t_mismatch();
    t_assign();
    t_clear();
    t_abort();
    t_ctrl_code();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule